// File: doc/BRIEF.md
# DSP Address Generation Unit

This block computes data-memory addresses for a single DSP data pointer. Each cycle a command may arrive with an addressing mode, a signed step and a flag choosing pre- or post-modification. One cycle later the block presents the effective address with a valid strobe, and in the same clock edge it moves the pointer to its successor. The successor comes from one of four update rules: plain linear stepping, a circular buffer bounded by a base and a length, a circular buffer of power-of-two size that wraps by masking, or bit-reversed stepping for radix-2 FFT reordering.

All wrap checks and bit-reversed carries are done in hardware on every access, so the software inner loop spends no instructions on bounds tests or index reordering. A small configuration port loads the pointer, the buffer base, the buffer length and the FFT size, given as log2 of the point count.

Top module: `dsp_agu`

## Requirements
- R1: After reset `addrValid` is 0, `addrOut` is 0, and the pointer, base, length and FFT-size registers are all 0.
- R2: With `cmdPre`=0 the address is the pointer value before the command, and the pointer then moves to its successor. In linear mode (`cmdMode`=0) the successor is pointer + sign-extended `cmdStep`, modulo 2^ADDR_W.
- R3: With `cmdPre`=1 the address is the successor value, which also becomes the new pointer.
- R4: `addrValid` is 1 in exactly the cycle after each command (`cmdValid`=1) and 0 otherwise. `addrOut` holds its value in cycles with no command.
- R5: In bounded circular mode (`cmdMode`=1), if pointer + step is above base + length − 1, the successor is pointer + step − length.
- R6: In bounded circular mode, if pointer + step is below base, the successor is pointer + step + length. Otherwise the successor is pointer + step. The step magnitude must not exceed the length.
- R7: In masked circular mode (`cmdMode`=2, length a power of two), the successor takes its bits above log2(length) from base and its low bits from (pointer + step) mod length.
- R8: In bit-reversed mode (`cmdMode`=3), with K the FFT-size register, the low K bits of the pointer are bit-reversed, the step is added, and the sum is reversed back. Bits above K are kept. For K=3, starting at 0 with step 1, the addresses are 0,4,2,6,1,5,3,7.
- R9: A configuration write in the same cycle as a command does not affect that command. The new value applies from the next command onward. `cfgSel` codes: 0 pointer, 1 base, 2 length, 3 FFT size (log2, values above ADDR_W are clamped).
- R10: A pointer write (`cfgSel`=0) in the same cycle as a command overrides that command's pointer update. The command's address is still produced normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdMode | input | 2 | 0 linear, 1 bounded circular, 2 masked circular, 3 bit-reversed |
| cmdStep | input | STEP_W | Signed step (two's complement) |
| cmdPre | input | 1 | 1 pre-modify, 0 post-modify |
| cfgWe | input | 1 | Configuration write enable |
| cfgSel | input | 2 | Configuration register select |
| cfgData | input | ADDR_W | Configuration write data |
| addrOut | output | ADDR_W | Effective address |
| addrValid | output | 1 | Address strobe, one cycle after a command |

## Verification
The hardest situations to reach are the collisions: a command in the same cycle as a configuration write that changes the wrap bounds or the pointer. The stimulus sets these up deliberately. It places the pointer at the last buffer slot and then issues a wrapping command together with a length write. The bench model then shows which length was applied, first on this command and again on the next. Random sequences then load fresh bases, lengths and FFT sizes before each burst of commands. Steps are kept within the buffer length, so up-wraps and down-wraps occur often in every mode.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    MODE_LINEAR     = 2'd0,
    MODE_CIRC_BOUND = 2'd1,
    MODE_CIRC_MASK  = 2'd2,
    MODE_BITREV     = 2'd3
  } agu_mode_e;

  typedef enum logic [1:0] {
    SEL_PTR  = 2'd0,
    SEL_BASE = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_FFT  = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic      capture;
    logic      preMod;
    agu_mode_e mode;
    logic      ptrLoad;
    logic      baseLoad;
    logic      lenLoad;
    logic      fftLoad;
  } agu_strobe_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic        cmdValid,
  input  logic [1:0]  cmdMode,
  input  logic        cmdPre,
  input  logic        cfgWe,
  input  logic [1:0]  cfgSel,
  output agu_strobe_t stb
);

  cfg_sel_e selDec;

  always_comb begin
    selDec       = cfg_sel_e'(cfgSel);
    stb.capture  = cmdValid;
    stb.preMod   = cmdValid & cmdPre;
    stb.mode     = agu_mode_e'(cmdMode);
    stb.ptrLoad  = cfgWe && (selDec == SEL_PTR);
    stb.baseLoad = cfgWe && (selDec == SEL_BASE);
    stb.lenLoad  = cfgWe && (selDec == SEL_LEN);
    stb.fftLoad  = cfgWe && (selDec == SEL_FFT);
  end

endmodule

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 8,
  parameter int LOG_W  = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  agu_strobe_t       stb,
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid,
  output logic [ADDR_W-1:0] ptrNow
);

  localparam int EXT_W = ADDR_W + 2;
  localparam int IDX_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam logic signed [EXT_W-1:0] ONE_EXT = 1;
  localparam logic [LOG_W-1:0] LOG_MAX = LOG_W'(ADDR_W);

  logic [ADDR_W-1:0] ptrQ, baseQ, lenQ, addrQ;
  logic [LOG_W-1:0]  fftLogQ;
  logic              validQ;

  logic signed [EXT_W-1:0] stepExt, sumExt, baseExt, lenExt, endExt, circExt;
  logic [ADDR_W-1:0] lenMask, maskNext;
  logic [ADDR_W-1:0] revMask, revPtr, revSum, brNext;
  logic [ADDR_W-1:0] nextPtr;

  function automatic logic [ADDR_W-1:0] bitRev(input logic [ADDR_W-1:0] v,
                                               input logic [LOG_W-1:0] k);
    logic [ADDR_W-1:0] r;
    r = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i < int'(k)) begin
        int j;
        j = int'(k) - 1 - i;
        r[i] = v[IDX_W'(j)];
      end
    end
    return r;
  endfunction

  // bounded circular buffer: compare against both ends in a widened signed domain
  always_comb begin
    stepExt = EXT_W'(signed'(step));
    sumExt  = signed'({2'b00, ptrQ}) + stepExt;
    baseExt = signed'({2'b00, baseQ});
    lenExt  = signed'({2'b00, lenQ});
    endExt  = baseExt + lenExt - ONE_EXT;
    if (sumExt > endExt)       circExt = sumExt - lenExt;
    else if (sumExt < baseExt) circExt = sumExt + lenExt;
    else                       circExt = sumExt;
  end

  // power-of-two buffer: wrap by keeping only the low bits of the sum
  always_comb begin
    lenMask  = lenQ - ADDR_W'(1);
    maskNext = (baseQ & ~lenMask) | (sumExt[ADDR_W-1:0] & lenMask);
  end

  // bit-reversed stepping: carry runs from the top of the K-bit field downward
  always_comb begin
    revMask = (ADDR_W'(1) << fftLogQ) - ADDR_W'(1);
    if (fftLogQ >= LOG_MAX) revMask = '1;
    revPtr  = bitRev(ptrQ & revMask, fftLogQ);
    revSum  = (revPtr + stepExt[ADDR_W-1:0]) & revMask;
    brNext  = (ptrQ & ~revMask) | bitRev(revSum, fftLogQ);
  end

  always_comb begin
    unique case (stb.mode)
      MODE_LINEAR:     nextPtr = sumExt[ADDR_W-1:0];
      MODE_CIRC_BOUND: nextPtr = circExt[ADDR_W-1:0];
      MODE_CIRC_MASK:  nextPtr = maskNext;
      MODE_BITREV:     nextPtr = brNext;
      default:         nextPtr = sumExt[ADDR_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ    <= '0;
      baseQ   <= '0;
      lenQ    <= '0;
      fftLogQ <= '0;
      addrQ   <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= stb.capture;
      if (stb.capture) addrQ <= stb.preMod ? nextPtr : ptrQ;
      if (stb.ptrLoad)      ptrQ <= cfgData;
      else if (stb.capture) ptrQ <= nextPtr;
      if (stb.baseLoad) baseQ <= cfgData;
      if (stb.lenLoad)  lenQ  <= cfgData;
      if (stb.fftLoad) begin
        if (cfgData > ADDR_W'(ADDR_W)) fftLogQ <= LOG_MAX;
        else                           fftLogQ <= cfgData[LOG_W-1:0];
      end
    end
  end

  assign addrOut   = addrQ;
  assign addrValid = validQ;
  assign ptrNow    = ptrQ;

endmodule

// File: rtl/dsp_agu.sv
module dsp_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdMode,
  input  logic [STEP_W-1:0] cmdStep,
  input  logic              cmdPre,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid
);

  localparam int LOG_W = $clog2(ADDR_W + 1);

  agu_strobe_t       stb;
  logic [ADDR_W-1:0] curPtr;

  agu_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdMode  (cmdMode),
    .cmdPre   (cmdPre),
    .cfgWe    (cfgWe),
    .cfgSel   (cfgSel),
    .stb      (stb)
  );

  agu_datapath #(.ADDR_W(ADDR_W), .STEP_W(STEP_W), .LOG_W(LOG_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .step      (cmdStep),
    .cfgData   (cfgData),
    .addrOut   (addrOut),
    .addrValid (addrValid),
    .ptrNow    (curPtr)
  );

endmodule

// File: rtl/dsp_agu_checker.sv
module dsp_agu_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdPre,
  input logic              cfgWe,
  input logic [1:0]        cfgSel,
  input logic [ADDR_W-1:0] cfgData,
  input logic [ADDR_W-1:0] addrOut,
  input logic              addrValid,
  input logic [ADDR_W-1:0] curPtr
);

  assert_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> addrValid);

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> (!addrValid && $stable(addrOut)));

  assert_post_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdPre) |=> (addrOut == $past(curPtr)));

  assert_pre_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdPre && !(cfgWe && cfgSel == 2'd0)) |=> (addrOut == curPtr));

  assert_ptr_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSel == 2'd0) |=> (curPtr == $past(cfgData)));

endmodule

bind dsp_agu dsp_agu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmdValid  (cmdValid),
  .cmdPre    (cmdPre),
  .cfgWe     (cfgWe),
  .cfgSel    (cfgSel),
  .cfgData   (cfgData),
  .addrOut   (addrOut),
  .addrValid (addrValid),
  .curPtr    (curPtr)
);

// File: tb/dsp_agu_bench.sv
`timescale 1ns/1ps
module dsp_agu_bench;

  localparam int ADDR_W = 16;
  localparam int STEP_W = 8;
  localparam int AMASK  = (1 << ADDR_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic [1:0]        cmdMode = 2'd0;
  logic [STEP_W-1:0] cmdStep = '0;
  logic              cmdPre = 1'b0;
  logic              cfgWe = 1'b0;
  logic [1:0]        cfgSel = 2'd0;
  logic [ADDR_W-1:0] cfgData = '0;
  logic [ADDR_W-1:0] addrOut;
  logic              addrValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mPtr = 0, mBase = 0, mLen = 0, mK = 0, mAddr = 0;

  always #4 clk = ~clk;

  dsp_agu #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_dsp_agu (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdMode(cmdMode),
    .cmdStep(cmdStep), .cmdPre(cmdPre), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .addrOut(addrOut), .addrValid(addrValid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int rev(input int v, input int k);
    int r = 0;
    for (int i = 0; i < k; i++) if (((v >> i) & 1) != 0) r |= 1 << (k - 1 - i);
    return r;
  endfunction

  function automatic int succ(input int md, input int p, input int s);
    int t, m, km, r;
    case (md)
      1: begin
        t = p + s;
        if (t > mBase + mLen - 1) t = t - mLen;
        else if (t < mBase) t = t + mLen;
        return t & AMASK;
      end
      2: begin
        m = (mLen - 1) & AMASK;
        return ((mBase & ~m) | ((p + s) & m)) & AMASK;
      end
      3: begin
        km = (mK >= ADDR_W) ? AMASK : ((1 << mK) - 1);
        r  = (rev(p & km, mK) + s) & km;
        return ((p & ~km) | rev(r, mK)) & AMASK;
      end
      default: return (p + s) & AMASK;
    endcase
  endfunction

  // one clock: drive at negedge, check at the following negedge
  task automatic cyc(input bit cv, input int md, input int st, input bit pr,
                     input bit cw, input int sel, input int dat, input string tag);
    int nx;
    cmdValid = cv; cmdMode = 2'(md); cmdStep = STEP_W'(st); cmdPre = pr;
    cfgWe = cw; cfgSel = 2'(sel); cfgData = ADDR_W'(dat);
    if (cv) begin
      nx = succ(md, mPtr, st);
      mAddr = pr ? nx : mPtr;
      mPtr = nx;
    end
    if (cw) begin
      case (sel)
        0: mPtr  = dat & AMASK;
        1: mBase = dat & AMASK;
        2: mLen  = dat & AMASK;
        default: mK = (dat > ADDR_W) ? ADDR_W : dat;
      endcase
    end
    @(negedge clk);
    cmdValid = 1'b0; cfgWe = 1'b0;
    chk({tag, " valid R4"}, int'(addrValid), int'(cv));
    chk({tag, " addr"}, int'(addrOut), mAddr);
  endtask

  task automatic cfg(input int sel, input int dat);
    cyc(0, 0, 0, 0, 1, sel, dat, "cfg R4");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seq [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("reset valid R1", int'(addrValid), 0);
    chk("reset addr R1", int'(addrOut), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R2 / R3 linear
    cyc(1, 0, 5, 0, 0, 0, 0, "R1 R2 post from reset ptr");
    chk("R2 post addr", int'(addrOut), 0);
    cyc(1, 0, -3, 1, 0, 0, 0, "R3 pre negative");
    chk("R3 pre addr", int'(addrOut), 2);
    cyc(0, 0, 0, 0, 0, 0, 0, "R4 idle hold");
    chk("R4 hold addr", int'(addrOut), 2);

    // R5 / R6 bounded circular
    cfg(1, 100); cfg(2, 10); cfg(0, 108);
    cyc(1, 1, 3, 0, 0, 0, 0, "R5 post wrap");
    chk("R5 post addr", int'(addrOut), 108);
    cyc(1, 1, 0, 1, 0, 0, 0, "R5 wrapped ptr");
    chk("R5 ptr after wrap", int'(addrOut), 101);
    cyc(1, 1, -4, 1, 0, 0, 0, "R6 down wrap");
    chk("R6 down wrap addr", int'(addrOut), 107);

    // R9 same-cycle length write uses old length
    cfg(0, 109);
    cyc(1, 1, 1, 1, 1, 2, 20, "R9 old length");
    chk("R9 old length addr", int'(addrOut), 100);
    cyc(1, 1, 15, 1, 0, 0, 0, "R9 new length");
    chk("R9 new length addr", int'(addrOut), 115);

    // R10 pointer write beats command update
    cyc(1, 0, 1, 0, 1, 0, 500, "R10 collide");
    chk("R10 addr from old ptr", int'(addrOut), 115);
    cyc(1, 0, 0, 0, 0, 0, 0, "R10 loaded");
    chk("R10 ptr loaded", int'(addrOut), 500);

    // R7 masked circular
    cfg(1, 'h40); cfg(2, 16); cfg(0, 'h4E);
    cyc(1, 2, 5, 1, 0, 0, 0, "R7 mask wrap");
    chk("R7 mask addr", int'(addrOut), 'h43);

    // R8 bit-reversed sequence
    cfg(3, 3); cfg(0, 0);
    for (int i = 0; i < 8; i++) begin
      cyc(1, 3, 1, 0, 0, 0, 0, "R8 bitrev");
      chk("R8 sequence", int'(addrOut), seq[i]);
    end
    cfg(0, 'h1230);
    cyc(1, 3, -1, 1, 0, 0, 0, "R8 high bits negative step");
    chk("R8 high bits", int'(addrOut), 'h1237);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int md, lim, s;
      md = int'($urandom % 4);
      case (md)
        1: begin
          cfg(1, int'($urandom % 30000));
          cfg(2, 1 + int'($urandom % 200));
          cfg(0, mBase + int'($urandom % mLen));
        end
        2: begin
          int n;
          n = int'($urandom % 8);
          cfg(2, 1 << n);
          cfg(1, int'($urandom % 65536) & ~((1 << n) - 1));
          cfg(0, int'($urandom % 65536));
        end
        3: begin
          cfg(3, int'($urandom % 7));
          cfg(0, int'($urandom % 65536));
        end
        default: cfg(0, int'($urandom % 65536));
      endcase
      for (int c = 0; c < 6; c++) begin
        if (md == 1) begin
          lim = (mLen - 1 > 127) ? 127 : mLen - 1;
          s = int'($urandom % (2 * lim + 1)) - lim;
        end else begin
          s = int'($urandom % 256) - 128;
        end
        cyc(1, md, s, bit'($urandom % 2), 0, 0, 0,
            (md == 1) ? "R5 R6 random" : (md == 2) ? "R7 random" :
            (md == 3) ? "R8 random" : "R2 R3 random");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule